// File: doc/BRIEF.md
# Split User/Supervisor Translation Lookaside Buffer

This block caches virtual-to-physical page translations for a processor that keeps separate address spaces for user mode and supervisor mode. It holds two independent direct-mapped banks, one per mode. A lookup takes a virtual page number and a mode bit. In the same cycle it returns the physical frame number, a read-only flag and a cache-inhibit flag, or it reports a miss. Misses are refilled by an external table walker through a one-cycle fill port. Entries carry no process tag, so software must flush a bank whenever it switches the address space behind that bank.

Invalidation is driven by the kind of register access that the processor performs:
- Reading the buffer control register empties both banks.
- Writing one of two flush codes to that register empties one bank.
- Writing either segment-table pointer empties the bank of that pointer's mode.
- A data write of zero in the purge function-code space removes the translation of one virtual page from both banks.

Top module: `tlb_split`

## Requirements
- R1: After reset every entry of both banks is invalid, and every lookup misses. On a miss, `lk_hit`, `lk_pfn`, `lk_ro` and `lk_ci` are all zero.
- R2: A fill writes the bank selected by `fill_super` (1 = supervisor, 0 = user). The fill stores the frame, read-only and cache-inhibit fields. A lookup of the same page number in that bank returns those fields from the next cycle on. The same page number in the other bank is not affected.
- R3: Each bank has 2^IDX_W entries (1024 by default). The entry index is bits [IDX_W-1:0] of the virtual page number and the tag is the remaining upper bits. A lookup whose tag differs from the stored tag misses. A fill replaces whatever entry was held at its index.
- R4: A read access (`reg_wr`=0) with `reg_sel`=2 (buffer control) invalidates every entry of both banks.
- R5: A write to `reg_sel`=2 invalidates the user bank only when the data is 0x0, and the supervisor bank only when the data is 0x8000. Any other value has no effect.
- R6: A write to `reg_sel`=1 (user segment pointer) invalidates the user bank. A write to `reg_sel`=0 (supervisor segment pointer) invalidates the supervisor bank. The data value does not matter. Reads of these selects, and any access to `reg_sel`=3, have no effect.
- R7: A data write with `wr_fc`=3 and `wr_data`=0 invalidates, in both banks, the entry at the page's index if its tag matches. Entries with another tag at that index, and entries at other indices, stay valid. A write with a nonzero value, or in any other function-code space, has no effect.
- R8: If a fill lands in the same cycle as an invalidation that covers its bank, the filled entry is left invalid. The same holds for a purge at the fill's index.
- R9: An invalidation takes effect at the clock edge that ends its cycle. A lookup during that cycle still sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_super | input | 1 | Lookup mode: 1 = supervisor bank, 0 = user bank |
| lk_vpn | input | VPN_W | Virtual page number to look up |
| lk_hit | output | 1 | Lookup hit |
| lk_pfn | output | PFN_W | Frame number on a hit, zero on a miss |
| lk_ro | output | 1 | Read-only flag on a hit |
| lk_ci | output | 1 | Cache-inhibit flag on a hit |
| fill_en | input | 1 | Write a translation this cycle |
| fill_super | input | 1 | Target bank of the fill |
| fill_vpn | input | VPN_W | Virtual page number being filled |
| fill_pfn | input | PFN_W | Frame number to store |
| fill_ro | input | 1 | Read-only flag to store |
| fill_ci | input | 1 | Cache-inhibit flag to store |
| reg_en | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_sel | input | 2 | 0 supervisor pointer, 1 user pointer, 2 buffer control, 3 unused |
| reg_wdata | input | DATA_W | Register write data |
| wr_en | input | 1 | Processor data-write strobe |
| wr_fc | input | 3 | Destination function code of the write |
| wr_vpn | input | VPN_W | Page number of the write address |
| wr_data | input | DATA_W | Data value of the write |

## Verification
A stuck or wrongly cleared valid bit shows at the lookup port in the first cycle after the edge concerned. A stale entry hits where a miss is expected, and a lost entry misses where a hit is expected. A misrouted flush decode empties the wrong bank. That is visible in the cycle after the access, because lookups then probe both banks. A purge that ignores its tag, or a fill that wins over a same-cycle invalidate, leaves a difference that is visible as soon as the affected page is looked up.

// File: rtl/tlb_split_pkg.sv
package tlb_split_pkg;

    localparam logic [2:0]  FC_PURGE        = 3'd3;
    localparam logic [31:0] CTL_USER_FLUSH  = 32'h0000_0000;
    localparam logic [31:0] CTL_SUPER_FLUSH = 32'h0000_8000;

    typedef enum logic [1:0] {
        SEL_SUP_PTR = 2'd0,
        SEL_USR_PTR = 2'd1,
        SEL_TLB_CTL = 2'd2,
        SEL_SPARE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic inv_user;
        logic inv_super;
        logic purge;
    } inv_req_t;

endpackage

// File: rtl/tlb_inv_decode.sv
module tlb_inv_decode
    import tlb_split_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              reg_en,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              wr_en,
    input  logic [2:0]        wr_fc,
    input  logic [DATA_W-1:0] wr_data,
    output inv_req_t          req
);

    always_comb begin
        req = '0;
        if (reg_en) begin
            case (reg_sel_e'(reg_sel))
                SEL_SUP_PTR: req.inv_super = reg_wr;
                SEL_USR_PTR: req.inv_user  = reg_wr;
                SEL_TLB_CTL: begin
                    if (!reg_wr) begin
                        req.inv_user  = 1'b1;
                        req.inv_super = 1'b1;
                    end else begin
                        req.inv_user  = (reg_wdata == DATA_W'(CTL_USER_FLUSH));
                        req.inv_super = (reg_wdata == DATA_W'(CTL_SUPER_FLUSH));
                    end
                end
                default: req = '0;
            endcase
        end
        req.purge = wr_en && (wr_fc == FC_PURGE) && (wr_data == '0);
    end

endmodule

// File: rtl/tlb_bank.sv
module tlb_bank #(
    parameter int IDX_W = 10,
    parameter int TAG_W = 10,
    parameter int PFN_W = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fill_en,
    input  logic [IDX_W-1:0]   fill_idx,
    input  logic [TAG_W-1:0]   fill_tag,
    input  logic [PFN_W-1:0]   fill_pfn,
    input  logic               fill_ro,
    input  logic               fill_ci,
    input  logic               inv_all,
    input  logic               purge_en,
    input  logic [IDX_W-1:0]   purge_idx,
    input  logic [TAG_W-1:0]   purge_tag,
    input  logic [IDX_W-1:0]   lk_idx,
    input  logic [TAG_W-1:0]   lk_tag,
    output logic               lk_hit,
    output logic [PFN_W-1:0]   lk_pfn,
    output logic               lk_ro,
    output logic               lk_ci,
    output logic [(1<<IDX_W)-1:0] vld_o
);

    localparam int ENTRIES = 1 << IDX_W;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [PFN_W-1:0] pfn;
        logic             ro;
        logic             ci;
    } entry_t;

    typedef struct packed {
        logic [ENTRIES-1:0] vld;
    } state_t;

    state_t st_d, st_q;
    entry_t ent_q [ENTRIES];
    entry_t lk_ent, pg_ent;
    logic   purge_match;

    always_comb begin
        lk_ent      = ent_q[lk_idx];
        pg_ent      = ent_q[purge_idx];
        purge_match = (st_q.vld[purge_idx] && (pg_ent.tag == purge_tag))
                   || (fill_en && (fill_idx == purge_idx));
        st_d = st_q;
        if (fill_en)
            st_d.vld[fill_idx] = 1'b1;
        if (purge_en && purge_match)
            st_d.vld[purge_idx] = 1'b0;
        if (inv_all)
            st_d.vld = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (fill_en)
            ent_q[fill_idx] <= '{tag: fill_tag, pfn: fill_pfn, ro: fill_ro, ci: fill_ci};
    end

    always_comb begin
        lk_hit = st_q.vld[lk_idx] && (lk_ent.tag == lk_tag);
        lk_pfn = lk_hit ? lk_ent.pfn : '0;
        lk_ro  = lk_hit && lk_ent.ro;
        lk_ci  = lk_hit && lk_ent.ci;
    end

    assign vld_o = st_q.vld;

endmodule

// File: rtl/tlb_split.sv
module tlb_split
    import tlb_split_pkg::*;
#(
    parameter int VPN_W  = 20,
    parameter int IDX_W  = 10,
    parameter int PFN_W  = 20,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_super,
    input  logic [VPN_W-1:0]  lk_vpn,
    output logic              lk_hit,
    output logic [PFN_W-1:0]  lk_pfn,
    output logic              lk_ro,
    output logic              lk_ci,
    input  logic              fill_en,
    input  logic              fill_super,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic              fill_ro,
    input  logic              fill_ci,
    input  logic              reg_en,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              wr_en,
    input  logic [2:0]        wr_fc,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [DATA_W-1:0] wr_data
);

    localparam int TAG_W   = VPN_W - IDX_W;
    localparam int ENTRIES = 1 << IDX_W;
    localparam int NBANK   = 2;

    inv_req_t req;
    logic               inv_user, inv_super, purge_en;
    logic               b_hit [NBANK];
    logic [PFN_W-1:0]   b_pfn [NBANK];
    logic               b_ro  [NBANK];
    logic               b_ci  [NBANK];
    logic [ENTRIES-1:0] b_vld [NBANK];
    logic [ENTRIES-1:0] user_vld, super_vld;

    tlb_inv_decode #(.DATA_W(DATA_W)) dec_i (
        .reg_en(reg_en), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .wr_en(wr_en), .wr_fc(wr_fc), .wr_data(wr_data), .req(req)
    );

    assign inv_user  = req.inv_user;
    assign inv_super = req.inv_super;
    assign purge_en  = req.purge;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam logic IS_SUP = (b == 1);
        tlb_bank #(.IDX_W(IDX_W), .TAG_W(TAG_W), .PFN_W(PFN_W)) bank_i (
            .clk(clk), .rst_n(rst_n),
            .fill_en(fill_en && (fill_super == IS_SUP)),
            .fill_idx(fill_vpn[IDX_W-1:0]), .fill_tag(fill_vpn[VPN_W-1:IDX_W]),
            .fill_pfn(fill_pfn), .fill_ro(fill_ro), .fill_ci(fill_ci),
            .inv_all(IS_SUP ? inv_super : inv_user),
            .purge_en(purge_en),
            .purge_idx(wr_vpn[IDX_W-1:0]), .purge_tag(wr_vpn[VPN_W-1:IDX_W]),
            .lk_idx(lk_vpn[IDX_W-1:0]), .lk_tag(lk_vpn[VPN_W-1:IDX_W]),
            .lk_hit(b_hit[b]), .lk_pfn(b_pfn[b]), .lk_ro(b_ro[b]), .lk_ci(b_ci[b]),
            .vld_o(b_vld[b])
        );
    end

    assign user_vld  = b_vld[0];
    assign super_vld = b_vld[1];

    always_comb begin
        lk_hit = lk_super ? b_hit[1] : b_hit[0];
        lk_pfn = lk_super ? b_pfn[1] : b_pfn[0];
        lk_ro  = lk_super ? b_ro[1]  : b_ro[0];
        lk_ci  = lk_super ? b_ci[1]  : b_ci[0];
    end

endmodule

// File: rtl/tlb_split_chk.sv
module tlb_split_chk
    import tlb_split_pkg::*;
#(
    parameter int ENTRIES = 1024
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_en,
    input logic               reg_wr,
    input logic [1:0]         reg_sel,
    input logic               inv_user,
    input logic               inv_super,
    input logic               purge_en,
    input logic               fill_en,
    input logic               fill_super,
    input logic               lk_super,
    input logic               lk_hit,
    input logic [ENTRIES-1:0] user_vld,
    input logic [ENTRIES-1:0] super_vld
);

    AST_CTL_READ_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && !reg_wr && reg_sel == SEL_TLB_CTL) |=> (user_vld == '0 && super_vld == '0)); // R4

    AST_USER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        inv_user |=> (user_vld == '0)); // R5

    AST_SUPER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        inv_super |=> (super_vld == '0)); // R6

    AST_SUPER_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (!inv_super && !purge_en && !(fill_en && fill_super)) |=> (super_vld == $past(super_vld))); // R2

    AST_USER_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_en && !fill_super) |=> ($countones(user_vld) <= $past($countones(user_vld)))); // R2

    AST_PURGE_ONE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (purge_en && !fill_en && !inv_user) |=> ($past($countones(user_vld)) - $countones(user_vld) <= 1)); // R7

    AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_super ? (super_vld != '0) : (user_vld != '0))); // R1

    AST_FILL_LOSES_TO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !fill_super && inv_user) |=> (user_vld == '0)); // R8

endmodule

bind tlb_split tlb_split_chk #(.ENTRIES(ENTRIES)) chk_i (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .inv_user(inv_user), .inv_super(inv_super), .purge_en(purge_en),
    .fill_en(fill_en), .fill_super(fill_super), .lk_super(lk_super), .lk_hit(lk_hit),
    .user_vld(user_vld), .super_vld(super_vld)
);

// File: tb/tlb_split_tb_top.sv
module tlb_split_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int VPN_W  = 20;
    localparam int IDX_W  = 10;
    localparam int TAG_W  = VPN_W - IDX_W;
    localparam int PFN_W  = 20;
    localparam int DATA_W = 32;
    localparam int ENT    = 1 << IDX_W;

    logic clk = 1'b0;
    logic rst_n;
    logic lk_super;
    logic [VPN_W-1:0] lk_vpn;
    logic lk_hit, lk_ro, lk_ci;
    logic [PFN_W-1:0] lk_pfn;
    logic fill_en, fill_super, fill_ro, fill_ci;
    logic [VPN_W-1:0] fill_vpn;
    logic [PFN_W-1:0] fill_pfn;
    logic reg_en, reg_wr;
    logic [1:0] reg_sel;
    logic [DATA_W-1:0] reg_wdata;
    logic wr_en;
    logic [2:0] wr_fc;
    logic [VPN_W-1:0] wr_vpn;
    logic [DATA_W-1:0] wr_data;

    int checks = 0;
    int errors = 0;

    bit             m_vld [2][ENT];
    logic [TAG_W-1:0] m_tag [2][ENT];
    logic [PFN_W-1:0] m_pfn [2][ENT];
    bit             m_ro  [2][ENT];
    bit             m_ci  [2][ENT];

    always #(CLK_PERIOD/2) clk = ~clk;

    tlb_split #(.VPN_W(VPN_W), .IDX_W(IDX_W), .PFN_W(PFN_W), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .lk_super(lk_super), .lk_vpn(lk_vpn),
        .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_ro(lk_ro), .lk_ci(lk_ci),
        .fill_en(fill_en), .fill_super(fill_super), .fill_vpn(fill_vpn),
        .fill_pfn(fill_pfn), .fill_ro(fill_ro), .fill_ci(fill_ci),
        .reg_en(reg_en), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .wr_en(wr_en), .wr_fc(wr_fc), .wr_vpn(wr_vpn), .wr_data(wr_data)
    );

    function automatic logic [VPN_W-1:0] mk_vpn(input logic [TAG_W-1:0] t, input logic [IDX_W-1:0] i);
        return {t, i};
    endfunction

    // Reference update of the expected contents, applied at each rising edge.
    function automatic void model_update();
        bit inv [2];
        bit purge;
        logic [IDX_W-1:0] fidx = fill_vpn[IDX_W-1:0];
        logic [IDX_W-1:0] pidx = wr_vpn[IDX_W-1:0];
        logic [TAG_W-1:0] ptag = wr_vpn[VPN_W-1:IDX_W];
        inv[0] = reg_en && ((reg_sel == 2'd1 && reg_wr) || (reg_sel == 2'd2 && !reg_wr)
                 || (reg_sel == 2'd2 && reg_wr && reg_wdata == 32'h0));
        inv[1] = reg_en && ((reg_sel == 2'd0 && reg_wr) || (reg_sel == 2'd2 && !reg_wr)
                 || (reg_sel == 2'd2 && reg_wr && reg_wdata == 32'h8000));
        purge  = wr_en && wr_fc == 3'd3 && wr_data == '0;
        for (int b = 0; b < 2; b++) begin
            bit fb = fill_en && (int'(fill_super) == b);
            if (fb) begin
                m_vld[b][fidx] = 1'b1;
                m_tag[b][fidx] = fill_vpn[VPN_W-1:IDX_W];
                m_pfn[b][fidx] = fill_pfn;
                m_ro[b][fidx]  = fill_ro;
                m_ci[b][fidx]  = fill_ci;
            end
            if (purge) begin
                if (fb && fidx == pidx) m_vld[b][pidx] = 1'b0;
                else if (m_tag[b][pidx] == ptag) m_vld[b][pidx] = 1'b0;
            end
            if (inv[b])
                for (int e = 0; e < ENT; e++) m_vld[b][e] = 1'b0;
        end
    endfunction

    task automatic idle();
        fill_en = 0; fill_super = 0; fill_vpn = '0; fill_pfn = '0; fill_ro = 0; fill_ci = 0;
        reg_en = 0; reg_wr = 0; reg_sel = '0; reg_wdata = '0;
        wr_en = 0; wr_fc = 3'd1; wr_vpn = '0; wr_data = '0;
    endtask

    task automatic cyc();
        @(posedge clk);
        model_update();
        @(negedge clk);
        idle();
    endtask

    task automatic chk_lk(input logic s, input logic [VPN_W-1:0] v, input string lbl);
        int b = s ? 1 : 0;
        logic [IDX_W-1:0] i = v[IDX_W-1:0];
        bit eh;
        logic [PFN_W-1:0] ep;
        bit er, ec;
        lk_super = s;
        lk_vpn   = v;
        #1;
        eh = m_vld[b][i] && (m_tag[b][i] == v[VPN_W-1:IDX_W]);
        ep = eh ? m_pfn[b][i] : '0;
        er = eh && m_ro[b][i];
        ec = eh && m_ci[b][i];
        checks++;
        if (lk_hit !== eh || lk_pfn !== ep || lk_ro !== er || lk_ci !== ec) begin
            errors++;
            $display("FAIL %s: sup=%0b vpn=%h act hit/pfn/ro/ci=%b/%h/%b/%b exp=%b/%h/%b/%b",
                     lbl, s, v, lk_hit, lk_pfn, lk_ro, lk_ci, eh, ep, er, ec);
        end
    endtask

    task automatic do_fill(input logic s, input logic [VPN_W-1:0] v, input logic [PFN_W-1:0] p,
                           input logic r, input logic c);
        fill_en = 1; fill_super = s; fill_vpn = v; fill_pfn = p; fill_ro = r; fill_ci = c;
    endtask

    task automatic do_reg(input logic w, input logic [1:0] sel, input logic [DATA_W-1:0] d);
        reg_en = 1; reg_wr = w; reg_sel = sel; reg_wdata = d;
    endtask

    task automatic do_wr(input logic [2:0] fc, input logic [VPN_W-1:0] v, input logic [DATA_W-1:0] d);
        wr_en = 1; wr_fc = fc; wr_vpn = v; wr_data = d;
    endtask

    task automatic fill_both(input logic [VPN_W-1:0] v);
        do_fill(0, v, 20'h11111, 0, 1); cyc();
        do_fill(1, v, 20'h22222, 1, 0); cyc();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: act=timeout exp=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [VPN_W-1:0] va, vb, vc, vd;
        logic [IDX_W-1:0] ipool [4];
        logic [TAG_W-1:0] tpool [4];
        void'($urandom(32'd1994));
        ipool = '{10'd0, 10'd5, 10'd6, 10'd1023};
        tpool = '{10'd0, 10'd3, 10'd7, 10'h3FF};
        for (int b = 0; b < 2; b++)
            for (int e = 0; e < ENT; e++) begin
                m_vld[b][e] = 0; m_tag[b][e] = '0; m_pfn[b][e] = '0; m_ro[b][e] = 0; m_ci[b][e] = 0;
            end
        idle();
        lk_super = 0; lk_vpn = '0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        va = mk_vpn(10'd3, 10'd5);
        vb = mk_vpn(10'd7, 10'd5);
        vc = mk_vpn(10'd3, 10'd6);
        vd = mk_vpn(10'h3FF, 10'd1023);

        // R1: empty after reset
        chk_lk(0, va, "R1 reset user");
        chk_lk(1, vd, "R1 reset super");
        cyc();

        // R2: fill goes to one bank only
        do_fill(0, va, 20'hABCDE, 1, 0); cyc();
        chk_lk(0, va, "R2 user fill hit");
        chk_lk(1, va, "R2 other bank miss");
        do_fill(1, va, 20'h12345, 0, 1); cyc();
        chk_lk(1, va, "R2 super fill hit");
        chk_lk(0, va, "R2 user kept");

        // R3: tag compare and replacement at a shared index
        chk_lk(0, vb, "R3 alias tag miss");
        do_fill(0, vb, 20'h0BEEF, 0, 1); cyc();
        chk_lk(0, vb, "R3 replacing fill hit");
        chk_lk(0, va, "R3 replaced entry miss");

        // R5 and R9: flush codes on the control register
        fill_both(va);
        do_reg(1, 2'd2, 32'h0);
        chk_lk(0, va, "R9 hit during flush cycle");
        cyc();
        chk_lk(0, va, "R5 user flush");
        chk_lk(1, va, "R5 super kept");
        fill_both(va);
        do_reg(1, 2'd2, 32'h1234); cyc();
        chk_lk(0, va, "R5 odd value no effect user");
        chk_lk(1, va, "R5 odd value no effect super");
        do_reg(1, 2'd2, 32'h8000); cyc();
        chk_lk(1, va, "R5 super flush");
        chk_lk(0, va, "R5 user kept");

        // R6: segment pointer writes, reads ignored
        fill_both(va);
        do_reg(0, 2'd1, 32'h0); cyc();
        do_reg(0, 2'd0, 32'h0); cyc();
        do_reg(1, 2'd3, 32'h0); cyc();
        chk_lk(0, va, "R6 pointer read ignored user");
        chk_lk(1, va, "R6 pointer read ignored super");
        do_reg(1, 2'd1, 32'hDEAD0000); cyc();
        chk_lk(0, va, "R6 user pointer flush");
        chk_lk(1, va, "R6 super kept");
        do_reg(1, 2'd0, 32'h00012000); cyc();
        chk_lk(1, va, "R6 super pointer flush");

        // R4: control read empties both
        fill_both(vd);
        do_reg(0, 2'd2, 32'h0); cyc();
        chk_lk(0, vd, "R4 read flush user");
        chk_lk(1, vd, "R4 read flush super");

        // R7: purge one page in both banks
        fill_both(va);
        fill_both(vc);
        do_wr(3'd3, va, 32'h5); cyc();
        chk_lk(0, va, "R7 nonzero purge ignored");
        do_wr(3'd1, va, 32'h0); cyc();
        chk_lk(1, va, "R7 other space ignored");
        do_wr(3'd3, vb, 32'h0); cyc();
        chk_lk(0, va, "R7 tag mismatch kept");
        do_wr(3'd3, va, 32'h0); cyc();
        chk_lk(0, va, "R7 purge user");
        chk_lk(1, va, "R7 purge super");
        chk_lk(0, vc, "R7 other index kept");

        // R8: fill loses to same-cycle invalidation
        do_fill(0, va, 20'h77777, 1, 1); do_reg(1, 2'd2, 32'h0); cyc();
        chk_lk(0, va, "R8 fill vs user flush");
        do_fill(0, vb, 20'h66666, 0, 0); do_wr(3'd3, va, 32'h0); cyc();
        chk_lk(0, vb, "R8 fill vs purge same index");
        do_fill(0, va, 20'h55555, 0, 0); do_reg(1, 2'd2, 32'h8000); cyc();
        chk_lk(0, va, "R8 other bank flush does not block");

        // Random mix over a small page pool (R2, R3, R7)
        for (int n = 0; n < 4000; n++) begin
            logic [VPN_W-1:0] rv;
            rv = mk_vpn(tpool[$urandom_range(0, 3)], ipool[$urandom_range(0, 3)]);
            if ($urandom_range(0, 9) < 4)
                do_fill($urandom_range(0, 1), rv, 20'($urandom), $urandom_range(0, 1), $urandom_range(0, 1));
            if ($urandom_range(0, 39) == 0)
                do_reg($urandom_range(0, 1), 2'($urandom_range(0, 3)),
                       ($urandom_range(0, 1) != 0) ? 32'h0 : 32'h8000);
            if ($urandom_range(0, 9) == 0)
                do_wr(($urandom_range(0, 3) != 0) ? 3'd3 : 3'd1,
                      mk_vpn(tpool[$urandom_range(0, 3)], ipool[$urandom_range(0, 3)]),
                      ($urandom_range(0, 5) != 0) ? 32'h0 : 32'h1);
            chk_lk($urandom_range(0, 1),
                   mk_vpn(tpool[$urandom_range(0, 3)], ipool[$urandom_range(0, 3)]),
                   "R2 R3 random lookup");
            cyc();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule